// File: doc/BRIEF.md
# Context-Switched Subarray Crossbar

This block is the central switch of one logic subarray tile in a time-multiplexed programmable array. Lines arriving from other subarrays are registered on entry. A small selector in front of each crossbar input then picks one of a few candidate sources, which are either registered network lines or lookup-table outputs from the tile. The crossbar maps the selected sources onto its outputs, and each output is registered. A registered crossbar output feeds a lookup-table input line inside the tile or goes out on a wire to another subarray. That wire traversal gets a pipeline stage of its own.

All selector and crossbar settings come from a routing memory that holds many configuration words. A sequencer broadcasts two values each microcycle: the timestep, which counts the evaluation, and the routing context, which picks the memory word in use. The context is the timestep modulo the number of stored words, so a short memory can serve a long evaluation. A lookup-table evaluation and one crossbar pass together make up a single stage: a source sampled in a cycle reaches its output register at the end of that same cycle. Software loads the memory through a plain write port and then pulses `start`. The sequencer runs until a programmed final timestep and then raises `done`.

The sequencer has three named states. IDLE waits after reset. RUN routes one context per microcycle. DONE holds the result. Its transitions are: IDLE to RUN on `start`; RUN to RUN while the timestep differs from the final value; RUN to DONE when the timestep equals the final value; DONE to RUN on `start`.

Top module: `subarray_xbar`

## Requirements
- R1: After reset, `xbar_q`, `wire_q`, `timestep`, `ctx`, `run` and `done` are all zero and the state is IDLE.
- R2: A cycle with `cfg_we` high stores `cfg_data` at context `cfg_addr`. The word layout is: bits [2i+1:2i] hold the source select of pre-crossbar selector i (i = 0..7), and bits [16+3k+2:16+3k] hold the number of the crossbar input that drives output k (k = 0..7).
- R3: Selector i picks its source by code: 0 is network line 2i, 1 is network line 2i+1, 2 is lookup-table output 2i, 3 is lookup-table output 2i+1. Every line is 4 bits wide, and line n sits at bits [4n+3:4n] of its bus.
- R4: A network line value is registered on entry, so a value present in cycle c is routed in cycle c+1. A lookup-table output is routed in the cycle it is present.
- R5: In a RUN cycle, output register k is loaded at the end of that cycle with the value on the crossbar input chosen by the current context word.
- R6: `ctx` always equals `timestep` modulo 64, so contexts are reused when the timestep is 64 or more.
- R7: `start` in IDLE or DONE moves to RUN with timestep 0. In RUN the timestep rises by one each cycle while it differs from `final_ts`.
- R8: When a RUN cycle has timestep equal to `final_ts`, the next state is DONE: `done` is high and `timestep` and `xbar_q` hold until the next `start`. Outside RUN, `xbar_q` never changes.
- R9: `start` during RUN is ignored. The timestep keeps counting and no restart happens.
- R10: `wire_q` equals the value that `xbar_q` had one cycle earlier.
- R11: With `final_ts` = 0, exactly one routing cycle takes place before DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation from timestep 0 |
| final_ts | input | 8 | Last timestep of the evaluation |
| cfg_we | input | 1 | Routing memory write enable |
| cfg_addr | input | 6 | Routing memory word address |
| cfg_data | input | 40 | Routing memory write data |
| net_in | input | 64 | Sixteen 4-bit incoming network lines |
| lut_out | input | 64 | Sixteen 4-bit lookup-table outputs |
| timestep | output | 8 | Broadcast current timestep |
| ctx | output | 6 | Broadcast current routing context |
| run | output | 1 | Sequencer is in RUN |
| done | output | 1 | Sequencer is in DONE |
| xbar_q | output | 32 | Registered crossbar outputs, eight 4-bit lines |
| wire_q | output | 32 | Inter-subarray wire stage, eight 4-bit lines |

## Verification
A wrong selector code, a wrong crossbar index or a stale context word shows up on `xbar_q` at the clock edge that ends the routing cycle, and on `wire_q` one edge later. A missing or extra network input register moves every network-sourced output by one cycle. That shift shows up as soon as the network lines change from one cycle to the next. A sequencer fault shows at once on `timestep`, `ctx` or `done`. A fault in the modulo reuse stays hidden until the timestep passes 63, so the run has to go beyond that point.

// File: rtl/subarray_xbar_pkg.sv
package subarray_xbar_pkg;
    localparam int XB_IN    = 8;   // crossbar inputs
    localparam int XB_OUT   = 8;   // crossbar outputs
    localparam int SRC_PER  = 4;   // sources per pre-crossbar selector
    localparam int LINE_W   = 4;   // bits per routed line
    localparam int N_CTX    = 64;  // routing contexts
    localparam int TS_W     = 8;   // timestep width

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/xbar_ctx_mem.sv
module xbar_ctx_mem #(
    parameter int N_CTX  = 64,
    parameter int WORD_W = 40,
    localparam int CTX_W = $clog2(N_CTX)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [CTX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CTX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] words [N_CTX];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Same-cycle read: the context word steers this cycle's routing.
    assign rd_data = words[rd_addr];
endmodule

// File: rtl/xbar_sequencer.sv
module xbar_sequencer
    import subarray_xbar_pkg::*;
#(
    parameter int N_CTX = 64,
    parameter int TS_W  = 8,
    localparam int CTX_W = $clog2(N_CTX),
    localparam bit CTX_POW2 = ((1 << CTX_W) == N_CTX) && (CTX_W <= TS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TS_W-1:0]  final_ts,
    output logic [TS_W-1:0]  timestep,
    output logic [CTX_W-1:0] ctx,
    output logic             run,
    output logic             done
);
    seq_state_e state_q, state_d;
    logic       go;
    logic       at_final;

    assign at_final = (timestep == final_ts);
    assign go       = start && (state_q != SEQ_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start)    state_d = SEQ_RUN;
            SEQ_RUN:  if (at_final) state_d = SEQ_DONE;
            SEQ_DONE: if (start)    state_d = SEQ_RUN;
            default:                state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run  = 1'b0;
        done = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_RUN:  run  = 1'b1;
            SEQ_DONE: done = 1'b1;
            default:  ;
        endcase
    end

    // timestep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timestep <= '0;
        end else if (go) begin
            timestep <= '0;
        end else if (run && !at_final) begin
            timestep <= timestep + 1'b1;
        end
    end

    // context = timestep modulo context count
    generate
        if (CTX_POW2) begin : g_ctx_bits
            assign ctx = timestep[CTX_W-1:0];
        end else begin : g_ctx_count
            logic [CTX_W-1:0] ctx_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctx_q <= '0;
                end else if (go) begin
                    ctx_q <= '0;
                end else if (run && !at_final) begin
                    ctx_q <= (ctx_q == CTX_W'(N_CTX - 1)) ? '0 : ctx_q + 1'b1;
                end
            end
            assign ctx = ctx_q;
        end
    endgenerate

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !run) |=> (run && timestep == '0)); // R7
    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !at_final) |=> (timestep == $past(timestep) + 1'b1)); // R7
    AST_FINAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && at_final) |=> done); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(timestep))); // R8
    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && !at_final) |=> (timestep != '0)); // R9
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath #(
    parameter int XB_IN   = 8,
    parameter int XB_OUT  = 8,
    parameter int SRC_PER = 4,
    parameter int LINE_W  = 4,
    localparam int PSEL_W = $clog2(SRC_PER),
    localparam int XSEL_W = $clog2(XB_IN),
    localparam int HALF   = SRC_PER / 2,
    localparam int NET_N  = XB_IN * HALF,
    localparam int LUT_N  = XB_IN * HALF,
    localparam int WORD_W = XB_IN * PSEL_W + XB_OUT * XSEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       route_en,
    input  logic [WORD_W-1:0]          cw,
    input  logic [NET_N*LINE_W-1:0]    net_in,
    input  logic [LUT_N*LINE_W-1:0]    lut_out,
    output logic [XB_OUT*LINE_W-1:0]   xbar_q,
    output logic [XB_OUT*LINE_W-1:0]   wire_q
);
    logic [NET_N*LINE_W-1:0]  net_q;
    logic [LINE_W-1:0]        pm [XB_IN];
    logic [XB_OUT*LINE_W-1:0] xbar_d;

    // network input register, ahead of the selectors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            net_q <= '0;
        end else begin
            net_q <= net_in;
        end
    end

    // pre-crossbar selectors: lower half of codes pick network, upper half LUTs
    generate
        for (genvar i = 0; i < XB_IN; i++) begin : g_pre
            logic [LINE_W-1:0] src [SRC_PER];
            logic [PSEL_W-1:0] sel;
            for (genvar s = 0; s < SRC_PER; s++) begin : g_src
                if (s < HALF) begin : g_net
                    assign src[s] = net_q[(i*HALF + s)*LINE_W +: LINE_W];
                end else begin : g_lut
                    assign src[s] = lut_out[(i*HALF + s - HALF)*LINE_W +: LINE_W];
                end
            end
            assign sel   = cw[i*PSEL_W +: PSEL_W];
            assign pm[i] = src[sel];
        end
    endgenerate

    // crossbar
    generate
        for (genvar k = 0; k < XB_OUT; k++) begin : g_xb
            logic [XSEL_W-1:0] xs;
            assign xs = cw[XB_IN*PSEL_W + k*XSEL_W +: XSEL_W];
            assign xbar_d[k*LINE_W +: LINE_W] = pm[xs];
        end
    endgenerate

    // crossbar output registers and the wire traversal stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xbar_q <= '0;
            wire_q <= '0;
        end else begin
            wire_q <= xbar_q;
            if (route_en) begin
                xbar_q <= xbar_d;
            end
        end
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !route_en |=> $stable(xbar_q)); // R8
    AST_WIRE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wire_q == $past(xbar_q))); // R10
endmodule

// File: rtl/subarray_xbar.sv
module subarray_xbar
    import subarray_xbar_pkg::*;
#(
    parameter int P_XB_IN   = XB_IN,
    parameter int P_XB_OUT  = XB_OUT,
    parameter int P_SRC_PER = SRC_PER,
    parameter int P_LINE_W  = LINE_W,
    parameter int P_N_CTX   = N_CTX,
    parameter int P_TS_W    = TS_W,
    localparam int CTX_W  = $clog2(P_N_CTX),
    localparam int PSEL_W = $clog2(P_SRC_PER),
    localparam int XSEL_W = $clog2(P_XB_IN),
    localparam int WORD_W = P_XB_IN * PSEL_W + P_XB_OUT * XSEL_W,
    localparam int NET_N  = P_XB_IN * (P_SRC_PER / 2),
    localparam int LUT_N  = P_XB_IN * (P_SRC_PER / 2)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [P_TS_W-1:0]             final_ts,
    input  logic                          cfg_we,
    input  logic [CTX_W-1:0]              cfg_addr,
    input  logic [WORD_W-1:0]             cfg_data,
    input  logic [NET_N*P_LINE_W-1:0]     net_in,
    input  logic [LUT_N*P_LINE_W-1:0]     lut_out,
    output logic [P_TS_W-1:0]             timestep,
    output logic [CTX_W-1:0]              ctx,
    output logic                          run,
    output logic                          done,
    output logic [P_XB_OUT*P_LINE_W-1:0]  xbar_q,
    output logic [P_XB_OUT*P_LINE_W-1:0]  wire_q
);
    logic [WORD_W-1:0] cur_word;

    xbar_sequencer #(
        .N_CTX (P_N_CTX),
        .TS_W  (P_TS_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .final_ts (final_ts),
        .timestep (timestep),
        .ctx      (ctx),
        .run      (run),
        .done     (done)
    );

    xbar_ctx_mem #(
        .N_CTX  (P_N_CTX),
        .WORD_W (WORD_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_addr (ctx),
        .rd_data (cur_word)
    );

    xbar_datapath #(
        .XB_IN   (P_XB_IN),
        .XB_OUT  (P_XB_OUT),
        .SRC_PER (P_SRC_PER),
        .LINE_W  (P_LINE_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .route_en (run),
        .cw       (cur_word),
        .net_in   (net_in),
        .lut_out  (lut_out),
        .xbar_q   (xbar_q),
        .wire_q   (wire_q)
    );

    AST_CTX_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        ctx == CTX_W'(timestep % P_N_CTX)); // R6
    AST_RUN_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && done)); // R8
endmodule

// File: tb/subarray_xbar_bench.sv
module subarray_xbar_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XW = 32;
    localparam int NW = 64;
    localparam int CWW = 40;

    typedef struct {
        logic [XW-1:0] x;
        logic [XW-1:0] w;
        logic [7:0]    ts;
        logic [5:0]    cx;
        logic          rn;
        logic          dn;
        string         tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [7:0]     final_ts = '0;
    logic           cfg_we = 1'b0;
    logic [5:0]     cfg_addr = '0;
    logic [CWW-1:0] cfg_data = '0;
    logic [NW-1:0]  net_in = '0;
    logic [NW-1:0]  lut_out = '0;
    logic [7:0]     timestep;
    logic [5:0]     ctx;
    logic           run;
    logic           done;
    logic [XW-1:0]  xbar_q;
    logic [XW-1:0]  wire_q;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    exp_t q[$];

    // bench model of the requirements
    logic [CWW-1:0] m_cfg [64];
    int             m_st = 0;   // 0 idle, 1 run, 2 done
    logic [7:0]     m_ts = '0;
    logic [XW-1:0]  m_x = '0;
    logic [NW-1:0]  m_net = '0;

    subarray_xbar u_subarray_xbar (
        .clk (clk), .rst_n (rst_n), .start (start), .final_ts (final_ts),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_data (cfg_data),
        .net_in (net_in), .lut_out (lut_out), .timestep (timestep), .ctx (ctx),
        .run (run), .done (done), .xbar_q (xbar_q), .wire_q (wire_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [XW-1:0] route(logic [CWW-1:0] w, logic [NW-1:0] nv, logic [NW-1:0] lv);
        logic [XW-1:0] r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            int i;
            int ps;
            i  = int'(w[16 + 3*k +: 3]);
            ps = int'(w[2*i +: 2]);
            if (ps < 2) r[4*k +: 4] = nv[4*(2*i + ps) +: 4];
            else        r[4*k +: 4] = lv[4*(2*i + ps - 2) +: 4];
        end
        return r;
    endfunction

    task automatic chk(string req, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", req, tag, act, exp, $time);
        end
    endtask

    // driver: one microcycle of stimulus plus the expected result after the edge
    task automatic cyc(bit st, bit we, logic [5:0] wa, logic [CWW-1:0] wd,
                       logic [7:0] fin, logic [NW-1:0] nv, logic [NW-1:0] lv, string tag);
        exp_t e;
        logic [XW-1:0] nx;
        @(negedge clk);
        start = st; cfg_we = we; cfg_addr = wa; cfg_data = wd;
        final_ts = fin; net_in = nv; lut_out = lv;
        nx = (m_st == 1) ? route(m_cfg[m_ts[5:0]], m_net, lv) : m_x;
        e.w = m_x;
        m_x = nx;
        m_net = nv;
        if (we) m_cfg[wa] = wd;
        if (m_st != 1 && st) begin
            m_st = 1; m_ts = '0;
        end else if (m_st == 1) begin
            if (m_ts == fin) m_st = 2;
            else m_ts = m_ts + 1'b1;
        end
        e.x = m_x; e.ts = m_ts; e.cx = m_ts[5:0];
        e.rn = (m_st == 1); e.dn = (m_st == 2); e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare right after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R5", e.tag, 64'(xbar_q), 64'(e.x));
                chk("R10", e.tag, 64'(wire_q), 64'(e.w));
                chk("R7", e.tag, 64'({run, timestep}), 64'({e.rn, e.ts}));
                chk("R6", e.tag, 64'(ctx), 64'(e.cx));
                chk("R8", e.tag, 64'(done), 64'(e.dn));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [NW-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [CWW-1:0] dw;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset", 64'({xbar_q, wire_q}), 64'(0));
        chk("R1", "reset", 64'({timestep, ctx, run, done}), 64'(0));
        rst_n = 1'b1;

        // R2 load every context while idle
        for (int c = 0; c < 64; c++) begin
            cyc(1'b0, 1'b1, 6'(c), CWW'(rnd64()), 8'd70, rnd64(), rnd64(), "R2 load idle");
        end

        // long run past 63 timesteps: R3 R4 R6 context reuse, R9 start ignored
        cyc(1'b1, 1'b0, '0, '0, 8'd70, rnd64(), rnd64(), "R7 start");
        for (int i = 0; i < 80; i++) begin
            cyc(i == 10, 1'b0, '0, '0, 8'd70, rnd64(), rnd64(),
                (i == 10) ? "R9 start in run" : "R3 R4 R6 R8 random");
        end

        // directed word for context 0: selector i code i%4, output k from input 7-k
        dw = '0;
        for (int i = 0; i < 8; i++) dw[2*i +: 2] = 2'(i % 4);
        for (int k = 0; k < 8; k++) dw[16 + 3*k +: 3] = 3'(7 - k);
        cyc(1'b0, 1'b1, 6'd0, dw, 8'd0, 64'h0123456789abcdef, '0, "R2 directed write");
        // R11 single routing cycle
        cyc(1'b1, 1'b0, '0, '0, 8'd0, 64'hfedcba9876543210, 64'h5a5a5a5aa5a5a5a5, "R11 R3 R4 one step");
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b0, '0, '0, 8'd0, rnd64(), rnd64(), "R11 R8 hold");
        end

        // restart from DONE
        cyc(1'b1, 1'b0, '0, '0, 8'd5, rnd64(), rnd64(), "R7 restart");
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 1'b0, '0, '0, 8'd5, rnd64(), rnd64(), "R7 R8 short run");
        end

        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule